// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This peripheral holds two independent down counters, each with its own interrupt line. A host reaches both counters through one synchronous register port. The port has a word address, a write strobe and write data, and the read data follows the address combinationally. Each counter owns six consecutive words. Counter 0 sits at words 0 to 5 and counter 1 at words 6 to 11. Addresses from 12 upward are outside the window.

A counter decrements only on clock cycles where the shared tick input is high. When a running counter expires, it raises its raw flag. In periodic mode it then restarts from its load value, and in one-shot mode it halts at zero. Software can change the period in two ways. A restarting load takes effect at once. A background load is picked up only at the next natural reload. The interrupt line of each counter is a level equal to its raw flag gated by its interrupt-enable bit.

Top module: `dualTimer`

## Requirements
- R1: After reset, every readable word of both counters is zero and both interrupt outputs are low.
- R2: Word addresses 12 and above read as zero, and writes to them change nothing in either counter.
- R3: The two counters are independent. Writing one counter's words or ticking it leaves the other counter's count, load value and flag as they would otherwise be.
- R4: The bank layout is: word offset 0 is the count, 1 is load, 2 is background load, 3 is control, 4 is raw status and 5 is masked status. Control bit 0 enables counting, bit 1 set selects one-shot mode, and bit 2 enables the interrupt. Starting from a load value L, after k ticks the raw flag (bit 0 of offset 4) is 1 exactly when k ≥ max(L,1). In periodic mode the count after k ticks is L−(k mod L), or 0 when L is 0. In one-shot mode the count is 0 once the flag has set and L−k before that, and it stays at 0.
- R5: Writing offset 4 with bit 0 set clears the raw flag. Writing it with bit 0 clear leaves the flag unchanged.
- R6: Masked status (offset 5, bit 0) and the counter's interrupt output both equal the raw flag AND control bit 2.
- R7: A write to the load offset while control bit 0 is set replaces the count with the written value in the next cycle and keeps it running.
- R8: A write to the background load offset stores the value in both the load and background words. The running count is not touched, and the new value is used at the next reload.
- R9: A control write with bit 0 set copies the load value into the count and starts counting. A control write with bit 0 clear freezes the count.
- R10: Writes to the count offset and to the masked status offset have no effect.
- R11: The count holds on every cycle where the tick input is low and no write reaches the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-advance enable, shared by both counters |
| addr | input | ADDR_W (4) | Word address |
| wrEn | input | 1 | Write strobe |
| wrData | input | CNT_W (32) | Write data |
| rdData | output | CNT_W (32) | Read data for the addressed word (combinational) |
| irq | output | N_CNT (2) | Level interrupt, one bit per counter |

## Verification
The hardest behaviour to reach from the ports is the reload edge: the exact tick on which the count passes 1→0, sets the flag and either reloads or stops. It matters most when a background load is pending or the load value is 0. The bench sweeps every load value from 0 to 4 in both modes and on both counters. For each one it applies a chosen number of ticks, from none to well past expiry, and compares against closed-form count and flag values. Directed sequences then line up a background load and a restarting load against a count already in flight.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int BANK_WORDS = 6;
  localparam int CTRL_EN = 0;
  localparam int CTRL_ONESHOT = 1;
  localparam int CTRL_IE = 2;

  localparam logic [2:0] OFF_COUNT  = 3'd0;
  localparam logic [2:0] OFF_LOAD   = 3'd1;
  localparam logic [2:0] OFF_BGLOAD = 3'd2;
  localparam logic [2:0] OFF_CTRL   = 3'd3;
  localparam logic [2:0] OFF_RAW    = 3'd4;
  localparam logic [2:0] OFF_MASKED = 3'd5;

  typedef struct packed {
    logic wrLoad;
    logic wrBg;
    logic wrCtrl;
    logic wrAck;
  } strobe_t;
endpackage

// File: rtl/timerCtrl.sv
module timerCtrl
  import dual_timer_pkg::*;
#(
  parameter int N_CNT = 2,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wrEn,
  input  logic [N_CNT-1:0][CNT_W-1:0] countVal,
  input  logic [N_CNT-1:0][CNT_W-1:0] loadVal,
  input  logic [N_CNT-1:0][CNT_W-1:0] bgVal,
  input  logic [N_CNT-1:0][2:0]       ctrlVal,
  input  logic [N_CNT-1:0]            rawFlag,
  output strobe_t [N_CNT-1:0]         strobes,
  output logic [CNT_W-1:0]            rdData
);
  localparam int IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [2:0]       off;

  // Split the word address into bank index and offset within the bank.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    off = '0;
    for (int i = 0; i < N_CNT; i++) begin
      if (int'(addr) >= i * BANK_WORDS && int'(addr) < (i + 1) * BANK_WORDS) begin
        hit = 1'b1;
        idx = IDX_W'(i);
        off = 3'(int'(addr) - i * BANK_WORDS);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_CNT; i++) begin
      strobes[i] = '0;
      if (wrEn && hit && idx == IDX_W'(i)) begin
        strobes[i].wrLoad = (off == OFF_LOAD);
        strobes[i].wrBg   = (off == OFF_BGLOAD);
        strobes[i].wrCtrl = (off == OFF_CTRL);
        strobes[i].wrAck  = (off == OFF_RAW);
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (hit) begin
      case (off)
        OFF_COUNT:  rdData = countVal[idx];
        OFF_LOAD:   rdData = loadVal[idx];
        OFF_BGLOAD: rdData = bgVal[idx];
        OFF_CTRL:   rdData = CNT_W'(ctrlVal[idx]);
        OFF_RAW:    rdData = CNT_W'(rawFlag[idx]);
        OFF_MASKED: rdData = CNT_W'(rawFlag[idx] & ctrlVal[idx][CTRL_IE]);
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/timerCounter.sv
module timerCounter
  import dual_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] loadReg,
  output logic [CNT_W-1:0] bgReg,
  output logic [2:0]       ctrl,
  output logic             raw,
  output logic             irq
);
  logic             running;
  logic             expire;
  logic [CNT_W-1:0] cntNext;
  logic             runNext;
  logic             rawNext;

  assign expire = tickEn && running && (count <= CNT_W'(1));

  always_comb begin
    cntNext = count;
    runNext = running;
    if (tickEn && running) begin
      if (expire) begin
        if (ctrl[CTRL_ONESHOT]) begin
          cntNext = '0;
          runNext = 1'b0;
        end else begin
          cntNext = loadReg;
        end
      end else begin
        cntNext = count - CNT_W'(1);
      end
    end
    // Register writes take priority over the tick.
    if (strb.wrCtrl) begin
      if (wrData[CTRL_EN]) begin
        cntNext = loadReg;
        runNext = 1'b1;
      end else begin
        cntNext = count;
        runNext = 1'b0;
      end
    end else if (strb.wrLoad && ctrl[CTRL_EN]) begin
      cntNext = wrData;
      runNext = 1'b1;
    end
  end

  always_comb begin
    rawNext = raw;
    if (strb.wrAck && wrData[0]) rawNext = 1'b0;
    if (expire) rawNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      loadReg <= '0;
      bgReg   <= '0;
      ctrl    <= '0;
      raw     <= 1'b0;
      running <= 1'b0;
    end else begin
      count   <= cntNext;
      running <= runNext;
      raw     <= rawNext;
      if (strb.wrCtrl) ctrl <= wrData[2:0];
      if (strb.wrLoad || strb.wrBg) loadReg <= wrData;
      if (strb.wrBg) bgReg <= wrData;
    end
  end

  assign irq = raw & ctrl[CTRL_IE];
endmodule

// File: rtl/dualTimer.sv
module dualTimer
  import dual_timer_pkg::*;
#(
  parameter int N_CNT = 2,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [N_CNT-1:0]  irq
);
  logic [N_CNT-1:0][CNT_W-1:0] countVal;
  logic [N_CNT-1:0][CNT_W-1:0] loadVal;
  logic [N_CNT-1:0][CNT_W-1:0] bgVal;
  logic [N_CNT-1:0][2:0]       ctrlVal;
  logic [N_CNT-1:0]            rawFlag;
  strobe_t [N_CNT-1:0]         strobes;

  timerCtrl #(.N_CNT(N_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .addr(addr), .wrEn(wrEn), .countVal(countVal), .loadVal(loadVal),
    .bgVal(bgVal), .ctrlVal(ctrlVal), .rawFlag(rawFlag),
    .strobes(strobes), .rdData(rdData)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    timerCounter #(.CNT_W(CNT_W)) uCnt (
      .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strobes[i]),
      .wrData(wrData), .count(countVal[i]), .loadReg(loadVal[i]),
      .bgReg(bgVal[i]), .ctrl(ctrlVal[i]), .raw(rawFlag[i]), .irq(irq[i])
    );
  end
endmodule

// File: rtl/dualTimerChecker.sv
module dualTimerChecker
  import dual_timer_pkg::*;
#(
  parameter int N_CNT = 2,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        tickEn,
  input logic [ADDR_W-1:0]           addr,
  input logic                        wrEn,
  input logic [CNT_W-1:0]            wrData,
  input logic [N_CNT-1:0]            irq,
  input logic [N_CNT-1:0][CNT_W-1:0] countVal,
  input logic [N_CNT-1:0][CNT_W-1:0] loadVal,
  input logic [N_CNT-1:0][2:0]       ctrlVal,
  input logic [N_CNT-1:0]            rawFlag
);
  localparam int WINDOW = N_CNT * BANK_WORDS;

  for (genvar i = 0; i < N_CNT; i++) begin : g_chk
    assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
      (!wrEn && !tickEn) |=> $stable(countVal[i]));

    assert_flag_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rawFlag[i]) |-> $past(tickEn));

    assert_ack_drops_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !tickEn && int'(addr) == i * BANK_WORDS + 4 && wrData[0]) |=> !irq[i]);

    assert_load_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && int'(addr) == i * BANK_WORDS + 1 && ctrlVal[i][CTRL_EN])
      |=> countVal[i] == $past(wrData));

    assert_outside_window_R2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !tickEn && int'(addr) >= WINDOW)
      |=> ($stable(countVal[i]) && $stable(loadVal[i]) && $stable(ctrlVal[i])
           && $stable(rawFlag[i])));
  end
endmodule

bind dualTimer dualTimerChecker #(.N_CNT(N_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
  .wrData(wrData), .irq(irq), .countVal(countVal), .loadVal(loadVal),
  .ctrlVal(ctrlVal), .rawFlag(rawFlag)
);

// File: tb/dualTimer_test.sv
module dualTimer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  irq;

  int nChecks = 0;
  int nFail = 0;

  dualTimer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a);
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = 4'(a);
    #1;
    v = rdData;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] snap [12];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 12; a++) begin
      rd(a, v);
      chk("R1 reset word", v, 0);
    end
    chk("R1 reset irq", 32'(irq), 0);

    // R4/R6: sweep of load value, mode and tick count on both counters
    for (int c = 0; c < 2; c++) begin
      for (int mode = 0; mode < 2; mode++) begin
        for (int L = 0; L < 5; L++) begin
          for (int k = 0; k < 10; k++) begin
            int b;
            int expCnt;
            int thr;
            logic expFlag;
            b = c * 6;
            wr(b + 3, 0);
            wr(b + 4, 1);
            wr(b + 1, L);
            wr(b + 3, 32'(1 | (mode << 1) | 4));
            ticks(k);
            thr = (L == 0) ? 1 : L;
            expFlag = (k >= thr);
            if (mode == 1) expCnt = expFlag ? 0 : L - k;
            else expCnt = (L == 0) ? 0 : L - (k % L);
            rd(b + 0, v);
            chk("R4 count after ticks", v, 32'(expCnt));
            rd(b + 4, v);
            chk("R4 raw flag", v, 32'(expFlag));
            rd(b + 5, v);
            chk("R6 masked status", v, 32'(expFlag));
            chk("R6 irq level", 32'(irq[c]), 32'(expFlag));
          end
        end
      end
      wr(c * 6 + 3, 0);
    end

    // R7: restarting load on counter 0
    wr(4, 1);
    wr(1, 10);
    wr(3, 1);
    ticks(3);
    rd(0, v); chk("R7 count before load", v, 7);
    wr(1, 20);
    rd(0, v); chk("R7 load restarts count", v, 20);
    ticks(2);
    rd(0, v); chk("R7 counting after load", v, 18);

    // R8: background load
    wr(2, 4);
    rd(0, v); chk("R8 count untouched", v, 18);
    rd(1, v); chk("R8 load word", v, 4);
    rd(2, v); chk("R8 background word", v, 4);
    ticks(17);
    rd(0, v); chk("R8 old period still running", v, 1);
    rd(4, v); chk("R8 no flag yet", v, 0);
    ticks(1);
    rd(0, v); chk("R8 reload uses new value", v, 4);
    rd(4, v); chk("R8 flag at reload", v, 1);

    // R9: freeze and restart through control
    wr(3, 0);
    ticks(3);
    rd(0, v); chk("R9 frozen count", v, 4);
    ticks(2);
    wr(1, 9);
    rd(0, v); chk("R9 load write while disabled", v, 4);
    wr(3, 1);
    rd(0, v); chk("R9 enable reloads", v, 9);
    ticks(1);
    rd(0, v); chk("R9 counting after enable", v, 8);

    // R10: writes to read-only offsets
    wr(0, 32'h55);
    wr(5, 32'h1);
    rd(0, v); chk("R10 count write ignored", v, 8);
    rd(4, v); chk("R10 raw unchanged", v, 1);
    rd(5, v); chk("R10 masked unchanged", v, 0);

    // R5: write-one-to-clear
    wr(4, 0);
    rd(4, v); chk("R5 write 0 keeps flag", v, 1);
    wr(4, 1);
    rd(4, v); chk("R5 write 1 clears flag", v, 0);

    // R6: interrupt enable gating
    wr(1, 3);
    wr(3, 5);
    ticks(3);
    chk("R6 irq with enable", 32'(irq[0]), 1);
    wr(3, 1);
    chk("R6 irq masked off", 32'(irq[0]), 0);
    rd(4, v); chk("R6 raw kept when masked", v, 1);
    rd(5, v); chk("R6 masked reads 0", v, 0);

    // R11: no ticks, no change
    rd(0, v);
    repeat (6) @(negedge clk);
    begin
      logic [31:0] v2;
      rd(0, v2);
      chk("R11 idle hold", v2, v);
    end

    // R3: independence
    wr(3, 0);
    wr(4, 1);
    wr(9, 0);
    wr(10, 1);
    wr(7, 7);
    wr(9, 1);
    ticks(2);
    rd(6, v); chk("R3 counter1 runs", v, 5);
    rd(0, v); chk("R3 counter0 unaffected", v, 3);
    wr(1, 50);
    rd(6, v); chk("R3 counter1 ignores counter0 load", v, 5);
    rd(7, v); chk("R3 counter1 load kept", v, 7);
    ticks(5);
    rd(10, v); chk("R3 counter1 flag", v, 1);
    rd(4, v); chk("R3 counter0 flag clear", v, 0);

    // R2: beyond-window accesses
    wr(9, 0);
    for (int a = 0; a < 12; a++) rd(a, snap[a]);
    for (int a = 12; a < 16; a++) wr(a, 32'hFFFF_FFFF);
    for (int a = 12; a < 16; a++) begin
      rd(a, v);
      chk("R2 out-of-window read", v, 0);
    end
    for (int a = 0; a < 12; a++) begin
      rd(a, v);
      chk("R2 window untouched", v, snap[a]);
    end
    chk("R2 irq untouched", 32'(irq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule